// File: doc/BRIEF.md
# I2C Slave Byte-Event Transaction Controller

This block sits behind an I2C slave serial engine and runs the byte-level protocol for it. Each time the engine finishes a byte, it raises a one-cycle event strobe. With the strobe come four status bits: whether the byte was an address or data, the transfer direction, whether the engine's receive buffer holds a byte, and whether the engine is holding the clock line low. The controller keeps its own record of where the transaction stands. It does not infer the transaction state from a start-condition flag. A stop can clear that flag before a late event is handled, so the controller never consults it.

On a write, incoming bytes go into a receive FIFO, which the host drains. On a read, bytes come from a transmit FIFO, which the host fills. When the transmit FIFO runs dry, the controller loads an all-ones filler byte so that the data line is never left driven low. When the receive FIFO overflows, the controller reads and drops the rest of that write, and it still releases the clock so the bus keeps moving. Any address byte starts the transaction afresh. A master NACK or a bus stop returns the controller to idle.

Top module: `i2cs_xact_ctrl`

## Requirements
- R1: After reset, `rxbuf_rd`, `txbuf_wr` and `clk_release` are low, both FIFOs are empty (`tx_empty`=1, `rx_empty`=1) and neither is full.
- R2: An event with `evt_is_data`=0 (address) and `evt_is_read`=0 (write) pulses `rxbuf_rd` and `clk_release`, whatever the state was before, and puts the controller in data-in.
- R3: An address event with `evt_is_read`=1 and a non-empty transmit FIFO pulses `rxbuf_rd`, `txbuf_wr` and `clk_release`. It loads the FIFO head onto `txbuf_data` and pops it, and it enters data-out. In data-out, later bytes are loaded in FIFO order.
- R4: A transmit load requested while the transmit FIFO is empty (at a read address or in data-out) puts 0xFF on `txbuf_data` and enters dummy-out. In dummy-out every load is 0xFF, even after the host refills the FIFO.
- R5: In data-out and dummy-out, a data event loads and releases only when `evt_buf_full`=0 and `evt_clk_held`=1. Any other data event produces no pulse and no pop.
- R6: In data-in, a data event with `evt_buf_full`=1 pulses `rxbuf_rd` and `clk_release` and pushes `rxbuf_data` into the receive FIFO. A data event with `evt_buf_full`=0 produces no pulse.
- R7: A data byte that arrives in data-in while the receive FIFO is full is dropped with `rxbuf_rd` and `clk_release` pulses, and the controller enters discard. In discard, every data byte is read, dropped and released, even after the host frees space. Only a new address leaves discard.
- R8: A data event with `evt_nack`=1 pulses `clk_release` only. It does not load, pop or read, and it sends the controller to idle.
- R9: A `bus_stop` pulse sends the controller to idle. In idle, a data event without NACK produces no pulse and no push.
- R10: Each FIFO holds FIFO_DEPTH bytes in arrival order. A push when full and a pop when empty are ignored, and the full and empty flags track the fill level.
- R11: `rxbuf_rd`, `txbuf_wr` and `clk_release` are single-cycle pulses. They are registered, appear in the cycle after the event edge, and never appear without an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Byte-event strobe from the serial engine |
| evt_is_data | input | 1 | 0 = address byte, 1 = data byte |
| evt_is_read | input | 1 | 1 = master reads, 0 = master writes |
| evt_buf_full | input | 1 | Engine receive buffer holds a byte |
| evt_clk_held | input | 1 | Engine is stretching the clock |
| evt_nack | input | 1 | Master answered the last sent byte with NACK |
| bus_stop | input | 1 | Stop condition seen on the bus |
| rxbuf_data | input | DATA_W | Byte in the engine receive buffer |
| rxbuf_rd | output | 1 | Read strobe that clears the engine receive buffer |
| txbuf_wr | output | 1 | Write strobe for the engine transmit buffer |
| txbuf_data | output | DATA_W | Byte written to the engine transmit buffer |
| clk_release | output | 1 | Release the held clock line |
| tx_push | input | 1 | Host push into the transmit FIFO |
| tx_push_data | input | DATA_W | Host byte for the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_pop | input | 1 | Host pop from the receive FIFO |
| rx_pop_data | output | DATA_W | Head of the receive FIFO |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |

## Verification
The bench builds the block with FIFO_DEPTH=4 and the default 8-bit width and 0xFF filler. The shallow depth lets a few bytes fill the receive FIFO, so the overflow into discard can be reached in a handful of events. It also lets a burst of five host pushes show a push being refused when the transmit FIFO is full. With that depth, a read of four bytes then drains the transmit FIFO and falls through to filler, so one transfer covers in-order loading, the empty-FIFO switch to dummy-out and the NACK exit.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA_IN,
        ST_DATA_OUT,
        ST_DISCARD,
        ST_DUMMY_OUT
    } xact_state_e;

    typedef struct packed {
        logic is_data;
        logic is_read;
        logic buf_full;
        logic clk_held;
        logic nack;
    } byte_evt_t;

    typedef struct packed {
        logic rd_rxbuf;
        logic wr_txbuf;
        logic use_fill;
        logic release_clk;
        logic push_rx;
        logic pop_tx;
    } ctl_act_t;

    localparam ctl_act_t ACT_NONE = '0;

    // Transmit slot is open when the engine buffer is drained and SCL is stretched.
    function automatic logic tx_slot_open(input byte_evt_t e);
        return !e.buf_full && e.clk_held;
    endfunction

endpackage

// File: rtl/i2cs_fifo.sv
module i2cs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int  CW   = $clog2(DEPTH + 1);
    localparam bit  POW2 = (DEPTH == (1 << AW));

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp, wp_nx, rp_nx;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    generate
        if (POW2) begin : g_wrap_nat
            assign wp_nx = wp + 1'b1;
            assign rp_nx = rp + 1'b1;
        end else begin : g_wrap_cmp
            assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp_nx;
            if (do_pop)  rp <= rp_nx;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
    import i2cs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      evt_valid,
    input  byte_evt_t evt,
    input  logic      bus_stop,
    input  logic      tx_empty,
    input  logic      rx_full,
    output ctl_act_t  act
);
    xact_state_e state_q, state_nx, eff;

    always_comb begin
        act      = ACT_NONE;
        state_nx = state_q;
        eff      = state_q;
        if (evt_valid) begin
            // An address byte always restarts the transaction.
            if (!evt.is_data) eff = ST_ADDR;
            if (evt.is_data && evt.nack) begin
                act.release_clk = 1'b1;
                state_nx        = ST_IDLE;
            end else begin
                case (eff)
                    ST_ADDR: begin
                        act.rd_rxbuf    = 1'b1;
                        act.release_clk = 1'b1;
                        if (!evt.is_read) begin
                            state_nx = ST_DATA_IN;
                        end else begin
                            act.wr_txbuf = 1'b1;
                            if (tx_empty) begin
                                act.use_fill = 1'b1;
                                state_nx     = ST_DUMMY_OUT;
                            end else begin
                                act.pop_tx = 1'b1;
                                state_nx   = ST_DATA_OUT;
                            end
                        end
                    end
                    ST_DATA_IN: begin
                        if (evt.buf_full) begin
                            act.rd_rxbuf    = 1'b1;
                            act.release_clk = 1'b1;
                            if (rx_full) state_nx = ST_DISCARD;
                            else         act.push_rx = 1'b1;
                        end
                    end
                    ST_DATA_OUT: begin
                        if (tx_slot_open(evt)) begin
                            act.wr_txbuf    = 1'b1;
                            act.release_clk = 1'b1;
                            if (tx_empty) begin
                                act.use_fill = 1'b1;
                                state_nx     = ST_DUMMY_OUT;
                            end else begin
                                act.pop_tx = 1'b1;
                            end
                        end
                    end
                    ST_DUMMY_OUT: begin
                        if (tx_slot_open(evt)) begin
                            act.wr_txbuf    = 1'b1;
                            act.use_fill    = 1'b1;
                            act.release_clk = 1'b1;
                        end
                    end
                    ST_DISCARD: begin
                        act.rd_rxbuf    = 1'b1;
                        act.release_clk = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
        if (bus_stop) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

endmodule

// File: rtl/i2cs_drive.sv
module i2cs_drive
    import i2cs_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] FILL_BYTE = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_act_t          act,
    input  logic [DATA_W-1:0] tx_head,
    output logic              rxbuf_rd,
    output logic              txbuf_wr,
    output logic [DATA_W-1:0] txbuf_data,
    output logic              clk_release
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rxbuf_rd    <= 1'b0;
            txbuf_wr    <= 1'b0;
            clk_release <= 1'b0;
            txbuf_data  <= FILL_BYTE;
        end else begin
            rxbuf_rd    <= act.rd_rxbuf;
            txbuf_wr    <= act.wr_txbuf;
            clk_release <= act.release_clk;
            if (act.wr_txbuf) txbuf_data <= act.use_fill ? FILL_BYTE : tx_head;
        end
    end

endmodule

// File: rtl/i2cs_xact_ctrl.sv
module i2cs_xact_ctrl
    import i2cs_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter int                FIFO_DEPTH = 16,
    parameter logic [DATA_W-1:0] FILL_BYTE  = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic              evt_is_data,
    input  logic              evt_is_read,
    input  logic              evt_buf_full,
    input  logic              evt_clk_held,
    input  logic              evt_nack,
    input  logic              bus_stop,
    input  logic [DATA_W-1:0] rxbuf_data,
    output logic              rxbuf_rd,
    output logic              txbuf_wr,
    output logic [DATA_W-1:0] txbuf_data,
    output logic              clk_release,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_push_data,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_pop_data,
    output logic              rx_full,
    output logic              rx_empty
);
    byte_evt_t         evt;
    ctl_act_t          act;
    logic [DATA_W-1:0] tx_head;

    assign evt.is_data  = evt_is_data;
    assign evt.is_read  = evt_is_read;
    assign evt.buf_full = evt_buf_full;
    assign evt.clk_held = evt_clk_held;
    assign evt.nack     = evt_nack;

    i2cs_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt       (evt),
        .bus_stop  (bus_stop),
        .tx_empty  (tx_empty),
        .rx_full   (rx_full),
        .act       (act)
    );

    i2cs_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (act.pop_tx),
        .head      (tx_head),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    i2cs_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push      (act.push_rx),
        .push_data (rxbuf_data),
        .pop       (rx_pop),
        .head      (rx_pop_data),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    i2cs_drive #(.DATA_W(DATA_W), .FILL_BYTE(FILL_BYTE)) drive_i (
        .clk         (clk),
        .rst         (rst),
        .act         (act),
        .tx_head     (tx_head),
        .rxbuf_rd    (rxbuf_rd),
        .txbuf_wr    (txbuf_wr),
        .txbuf_data  (txbuf_data),
        .clk_release (clk_release)
    );

endmodule

// File: rtl/i2cs_xact_ctrl_chk.sv
module i2cs_xact_ctrl_chk #(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] FILL_BYTE = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              evt_valid,
    input logic              evt_is_data,
    input logic              evt_nack,
    input logic              rxbuf_rd,
    input logic              txbuf_wr,
    input logic [DATA_W-1:0] txbuf_data,
    input logic              clk_release,
    input logic              tx_push,
    input logic              tx_empty,
    input logic              rx_pop,
    input logic              rx_full
);
    // R4: a load decided while the transmit FIFO was empty carries the filler
    a_r4_fill_when_empty: assert property (@(posedge clk) disable iff (rst)
        txbuf_wr && $past(tx_empty) |-> txbuf_data == FILL_BYTE);

    // R11: no release pulse without an event on the previous edge
    a_r11_release_needs_event: assert property (@(posedge clk) disable iff (rst)
        clk_release |-> $past(evt_valid));

    // R6: every read of the engine receive buffer comes with a clock release
    a_r6_read_releases: assert property (@(posedge clk) disable iff (rst)
        rxbuf_rd |-> clk_release);

    // R3: every transmit load comes with a clock release
    a_r3_load_releases: assert property (@(posedge clk) disable iff (rst)
        txbuf_wr |-> clk_release);

    // R8: a NACK data event never loads the transmit buffer
    a_r8_nack_no_load: assert property (@(posedge clk) disable iff (rst)
        $past(evt_valid && evt_is_data && evt_nack) |-> !txbuf_wr);

    // R10: an empty transmit FIFO stays empty without a host push
    a_r10_tx_empty_holds: assert property (@(posedge clk) disable iff (rst)
        tx_empty && !tx_push |=> tx_empty);

    // R10: a full receive FIFO stays full without a host pop
    a_r10_rx_full_holds: assert property (@(posedge clk) disable iff (rst)
        rx_full && !rx_pop |=> rx_full);

endmodule

bind i2cs_xact_ctrl i2cs_xact_ctrl_chk #(.DATA_W(DATA_W), .FILL_BYTE(FILL_BYTE)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .evt_valid   (evt_valid),
    .evt_is_data (evt_is_data),
    .evt_nack    (evt_nack),
    .rxbuf_rd    (rxbuf_rd),
    .txbuf_wr    (txbuf_wr),
    .txbuf_data  (txbuf_data),
    .clk_release (clk_release),
    .tx_push     (tx_push),
    .tx_empty    (tx_empty),
    .rx_pop      (rx_pop),
    .rx_full     (rx_full)
);

// File: tb/i2cs_xact_ctrl_tb.sv
module i2cs_xact_ctrl_tb_top;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          evt_valid = 1'b0, evt_is_data = 1'b0, evt_is_read = 1'b0;
    logic          evt_buf_full = 1'b0, evt_clk_held = 1'b0, evt_nack = 1'b0;
    logic          bus_stop = 1'b0;
    logic [DW-1:0] rxbuf_data = '0;
    logic          rxbuf_rd, txbuf_wr, clk_release;
    logic [DW-1:0] txbuf_data;
    logic          tx_push = 1'b0;
    logic [DW-1:0] tx_push_data = '0;
    logic          tx_full, tx_empty;
    logic          rx_pop = 1'b0;
    logic [DW-1:0] rx_pop_data;
    logic          rx_full, rx_empty;

    int  vectors = 0;
    int  miscompares = 0;
    int  cyc = 0;
    bit  mon_en = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        int            due;
        bit            rd;
        bit            wr;
        bit            rel;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    i2cs_xact_ctrl #(.DATA_W(DW), .FIFO_DEPTH(4), .FILL_BYTE(8'hFF)) dut_i (
        .clk, .rst, .evt_valid, .evt_is_data, .evt_is_read, .evt_buf_full,
        .evt_clk_held, .evt_nack, .bus_stop, .rxbuf_data, .rxbuf_rd, .txbuf_wr,
        .txbuf_data, .clk_release, .tx_push, .tx_push_data, .tx_full, .tx_empty,
        .rx_pop, .rx_pop_data, .rx_full, .rx_empty
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] want);
        vectors++;
        if (got !== want) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h", tag, got, want);
        end
    endtask

    // Monitor: pops the scoreboard entry due this cycle, otherwise expects no pulse (R11).
    always @(negedge clk) begin
        exp_t e;
        if (mon_en && !done) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                e = exp_q.pop_front();
                vectors++;
                if (rxbuf_rd !== e.rd || txbuf_wr !== e.wr || clk_release !== e.rel ||
                    (e.wr && txbuf_data !== e.data)) begin
                    miscompares++;
                    $display("FAIL %s: rd/wr/rel/data got %b%b%b/%h expected %b%b%b/%h",
                             e.tag, rxbuf_rd, txbuf_wr, clk_release, txbuf_data,
                             e.rd, e.wr, e.rel, e.data);
                end
            end else begin
                vectors++;
                if (rxbuf_rd !== 1'b0 || txbuf_wr !== 1'b0 || clk_release !== 1'b0) begin
                    miscompares++;
                    $display("FAIL R11: stray pulse rd/wr/rel got %b%b%b expected 000",
                             rxbuf_rd, txbuf_wr, clk_release);
                end
            end
        end
    end

    // Driver: applies one byte event and queues the expected pulses.
    task automatic ev(input bit d, input bit r, input bit bf, input bit hd, input bit nk,
                      input logic [DW-1:0] rxd, input bit erd, input bit ewr,
                      input logic [DW-1:0] edat, input bit erel, input string tag);
        @(negedge clk);
        evt_valid = 1'b1; evt_is_data = d; evt_is_read = r;
        evt_buf_full = bf; evt_clk_held = hd; evt_nack = nk; rxbuf_data = rxd;
        exp_q.push_back('{cyc + 1, erd, ewr, erel, edat, tag});
        @(posedge clk); #1;
        evt_valid = 1'b0; evt_nack = 1'b0;
    endtask

    task automatic push_tx(input logic [DW-1:0] b);
        @(negedge clk);
        tx_push = 1'b1; tx_push_data = b;
        @(posedge clk); #1;
        tx_push = 1'b0;
    endtask

    task automatic pop_rx(input logic [DW-1:0] want, input string tag);
        @(negedge clk);
        chk(tag, rx_pop_data, want);
        rx_pop = 1'b1;
        @(posedge clk); #1;
        rx_pop = 1'b0;
    endtask

    task automatic stop_pulse();
        @(negedge clk);
        bus_stop = 1'b1;
        @(posedge clk); #1;
        bus_stop = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", {rxbuf_rd, txbuf_wr, clk_release}, 0);
        chk("R1", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
        mon_en = 1'b1;

        // R2 write address, R6 data-in pushes and ignores buf_full=0
        ev(0,0,0,0,0, 8'h00, 1,0,8'h00,1, "R2");
        ev(1,0,1,0,0, 8'hA1, 1,0,8'h00,1, "R6");
        ev(1,0,1,0,0, 8'hA2, 1,0,8'h00,1, "R6");
        ev(1,0,0,0,0, 8'hEE, 0,0,8'h00,0, "R6");
        pop_rx(8'hA1, "R6");
        pop_rx(8'hA2, "R6");
        @(negedge clk); chk("R6", rx_empty, 1);

        // R3 read from FIFO, R5 gating, R4 filler and dummy-out
        push_tx(8'h11);
        push_tx(8'h22);
        ev(0,1,0,0,0, 8'h00, 1,1,8'h11,1, "R3");
        ev(1,1,0,1,0, 8'h00, 0,1,8'h22,1, "R3");
        ev(1,1,1,1,0, 8'h00, 0,0,8'h00,0, "R5");
        ev(1,1,0,0,0, 8'h00, 0,0,8'h00,0, "R5");
        ev(1,1,0,1,0, 8'h00, 0,1,8'hFF,1, "R4");
        @(negedge clk); chk("R4", tx_empty, 1);
        push_tx(8'h33);
        ev(1,1,0,1,0, 8'h00, 0,1,8'hFF,1, "R4");
        ev(1,1,0,1,1, 8'h00, 0,0,8'h00,1, "R8");
        ev(1,1,0,1,0, 8'h00, 0,0,8'h00,0, "R8");
        @(negedge clk); chk("R8", tx_empty, 0);
        ev(0,1,0,0,0, 8'h00, 1,1,8'h33,1, "R3");
        ev(1,1,0,1,0, 8'h00, 0,1,8'hFF,1, "R4");
        ev(1,1,0,1,1, 8'h00, 0,0,8'h00,1, "R8");

        // R4 filler straight at a read address
        ev(0,1,0,0,0, 8'h00, 1,1,8'hFF,1, "R4");
        ev(1,1,0,1,1, 8'h00, 0,0,8'h00,1, "R8");

        // R7 overflow into discard
        ev(0,0,0,0,0, 8'h00, 1,0,8'h00,1, "R2");
        for (int i = 0; i < 4; i++) ev(1,0,1,0,0, 8'hB0 + 8'(i), 1,0,8'h00,1, "R6");
        @(negedge clk); chk("R10", rx_full, 1);
        ev(1,0,1,0,0, 8'hB4, 1,0,8'h00,1, "R7");
        pop_rx(8'hB0, "R7");
        ev(1,0,1,0,0, 8'hB5, 1,0,8'h00,1, "R7");
        ev(0,0,0,0,0, 8'h00, 1,0,8'h00,1, "R2");
        ev(1,0,1,0,0, 8'hB6, 1,0,8'h00,1, "R2");
        pop_rx(8'hB1, "R7");
        pop_rx(8'hB2, "R7");
        pop_rx(8'hB3, "R7");
        pop_rx(8'hB6, "R7");
        @(negedge clk); chk("R7", rx_empty, 1);

        // R9 stop returns to idle
        ev(0,0,0,0,0, 8'h00, 1,0,8'h00,1, "R2");
        stop_pulse();
        ev(1,0,1,0,0, 8'h5A, 0,0,8'h00,0, "R9");
        @(negedge clk); chk("R9", rx_empty, 1);

        // R10 FIFO limits: push when full and pop when empty ignored
        for (int i = 0; i < 5; i++) push_tx(8'hC0 + 8'(i));
        @(negedge clk); chk("R10", tx_full, 1);
        pop_rx(rx_pop_data, "R10");
        @(negedge clk); chk("R10", {rx_empty, rx_full}, 2'b10);
        ev(0,1,0,0,0, 8'h00, 1,1,8'hC0,1, "R10");
        ev(1,1,0,1,0, 8'h00, 0,1,8'hC1,1, "R10");
        ev(1,1,0,1,0, 8'h00, 0,1,8'hC2,1, "R10");
        ev(1,1,0,1,0, 8'h00, 0,1,8'hC3,1, "R10");
        ev(1,1,0,1,0, 8'h00, 0,1,8'hFF,1, "R10");
        ev(1,1,0,1,1, 8'h00, 0,0,8'h00,1, "R8");

        // R2 a write address in the middle of a read restarts the transaction
        push_tx(8'hD0);
        ev(0,1,0,0,0, 8'h00, 1,1,8'hD0,1, "R3");
        ev(0,0,0,0,0, 8'h00, 1,0,8'h00,1, "R2");
        ev(1,0,1,0,0, 8'hE0, 1,0,8'h00,1, "R2");
        pop_rx(8'hE0, "R2");

        repeat (3) @(negedge clk);
        chk("R11", exp_q.size(), 0);
        finish_run();
    end

endmodule